// File: doc/BRIEF.md
# Programmable Fixed-Point MAC Engine

This block is a small signal-processing coprocessor. It runs a stored program from a 256-word instruction memory. The program uses three kinds of instruction. A multiply-accumulate takes a 16-bit coefficient from a 64-word coefficient memory and a 16-bit sample from a 1024-word data bank, and adds their product into a 40-bit accumulator. A store scales the accumulator back to 16 bits and writes the result. A jump changes the program counter or ends the program. Each instruction executes in a single cycle.

There are two data banks. The engine computes on one of them while the host reads and writes the other through a simple register port. A swap request exchanges the two banks, but the exchange only happens while the engine is idle. A 3-bit select input picks one of eight program entry points when a run starts. Four monitor registers hold the most recent stored results and can be read by the host at any time, including while a program is running. A multiply-accumulate can also copy the sample it reads one word forward, which builds a delay line inside a 32-word window.

Top module: `macEngine`

## Requirements
- R1: After reset, `busy` is 0, `engBank` is 0 and all four monitor words read 0.
- R2: An instruction with bits [15:14]=00 is a multiply-accumulate. Bit 13 set first clears the accumulator. Bits [11:6] give the coefficient address and bits [5:0] give the data offset, which is added to the data base to form the sample address. The signed 16×16 product is added into a 40-bit accumulator.
- R3: An instruction with bits [15:14]=01 is a store. Bits [11:10]=q select a right shift of 12+q, which covers Q12 to Q15. Bits [9:8] select the monitor slot that receives the result, and bits [5:0] select the data offset that receives the result.
- R4: When store bit 13 is set, half an LSB of the selected shift (1<<(11+q)) is added before the arithmetic shift. When it is clear, the result is truncated.
- R5: When store bit 12 is set, a shifted value above 32767 becomes 0x7FFF and a value below -32768 becomes 0x8000. When bit 12 is clear, the low 16 bits are kept.
- R6: A summation holds at most 32 terms. Once 32 products have been accumulated since the last clearing multiply-accumulate, further multiply-accumulates leave the accumulator unchanged.
- R7: A `start` pulse while idle begins execution at address `progSel`×32.
- R8: An instruction with bits [15:14]=10 is a jump to the address in bits [7:0]. When bit 13 is also set, the jump ends the run and `busy` falls.
- R9: When multiply-accumulate bit 12 is set, the sample read is also written to the next address, unless the low 5 bits of the offset are 31. In that case nothing is written, so the move stays inside a 32-word window.
- R10: The host port (`hostSel`=2) reaches the bank the engine is not using. A `swapReq` takes effect on the next idle cycle, so `engBank` never changes while `busy` is 1.
- R11: The host reads monitor slot `hostAddr[1:0]` with `hostSel`=3 at any time, including while the engine is running.
- R12: The engine executes one instruction per cycle, so `busy` stays high for exactly the number of instructions the run executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a program when idle |
| progSel | input | 3 | Program entry select |
| swapReq | input | 1 | Requests a data bank exchange |
| busy | output | 1 | Program running |
| engBank | output | 1 | Bank used by the engine |
| hostWe | input | 1 | Host write strobe |
| hostSel | input | 2 | 0 instructions, 1 coefficients, 2 host bank, 3 data base (write) / monitor (read) |
| hostAddr | input | 10 | Host word address |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data |

## Verification
The bench targets several corner cases, each of which exposes a specific kind of faulty design:

- **Saturation:** sums are driven past the 16-bit range in both directions. A design with an inverted clamp, or one that wraps instead of clamping, would return wrong words.
- **Rounding:** a 1.5-LSB value tells rounding apart from truncation. A misplaced half-LSB would give 1 where 2 is expected.
- **Term cap:** a 40-term run exceeds the cap. A design without the cap would report 0x50 instead of 0x40.
- **Swap and monitor:** a swap is requested in the middle of a run, and a monitor slot is read while the engine runs. A design that swaps early, or that hides the monitor during a run, would fail there.
- **Delay window:** the delay move is tried at the window edge. A design that ignores the window limit would corrupt the word just past it.

// File: rtl/macPkg.sv
package macPkg;
  localparam int DATA_W  = 16;
  localparam int ACC_W   = 40;
  localparam int IADDR_W = 8;
  localparam int CADDR_W = 6;
  localparam int BADDR_W = 10;
  localparam int SEL_W   = 3;
  localparam int MON_N   = 4;
  localparam int TERM_MAX = 32;
  localparam int Q_BASE  = 12;

  typedef enum logic [1:0] {
    OP_MAC = 2'b00,
    OP_STR = 2'b01,
    OP_JMP = 2'b10,
    OP_NOP = 2'b11
  } opT;

  typedef struct packed {
    logic       macEn;
    logic       clrAcc;
    logic       dlyEn;
    logic       strEn;
    logic       rnd;
    logic       sat;
    logic [1:0] qSel;
    logic [1:0] monSlot;
    logic [5:0] coefAddr;
    logic [5:0] dataOfs;
  } strobeT;
endpackage

// File: rtl/macCtrl.sv
module macCtrl
  import macPkg::*;
#(
  parameter int IAW = IADDR_W,
  parameter int PSW = SEL_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [PSW-1:0] progSel,
  input  logic           swapReq,
  input  logic [15:0]    instr,
  output logic [IAW-1:0] pc,
  output logic           busy,
  output logic           engBank,
  output strobeT         stb
);
  localparam int ENTRY_W = IAW - PSW;

  opT   op;
  logic swapPend;

  assign op = opT'(instr[15:14]);

  // decode the current instruction into datapath strobes
  always_comb begin
    stb = '0;
    if (busy) begin
      case (op)
        OP_MAC: begin
          stb.macEn    = 1'b1;
          stb.clrAcc   = instr[13];
          stb.dlyEn    = instr[12];
          stb.coefAddr = instr[11:6];
          stb.dataOfs  = instr[5:0];
        end
        OP_STR: begin
          stb.strEn   = 1'b1;
          stb.rnd     = instr[13];
          stb.sat     = instr[12];
          stb.qSel    = instr[11:10];
          stb.monSlot = instr[9:8];
          stb.dataOfs = instr[5:0];
        end
        default: ;
      endcase
    end
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      pc   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        pc   <= {progSel, {ENTRY_W{1'b0}}};
      end
    end else if (op == OP_JMP) begin
      pc <= instr[IAW-1:0];
      if (instr[13]) busy <= 1'b0;
    end else begin
      pc <= pc + 1'b1;
    end
  end

  // bank exchange only between runs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      engBank  <= 1'b0;
      swapPend <= 1'b0;
    end else if (!busy && (swapPend || swapReq)) begin
      engBank  <= ~engBank;
      swapPend <= 1'b0;
    end else if (swapReq) begin
      swapPend <= 1'b1;
    end
  end

  p_bank_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> engBank == $past(engBank));

  p_entry_r7: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && pc == {$past(progSel), {ENTRY_W{1'b0}}}));

  p_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && op == OP_JMP && instr[13]) |=> !busy);
endmodule

// File: rtl/macDatapath.sv
module macDatapath
  import macPkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int AW   = ACC_W,
  parameter int IAW  = IADDR_W,
  parameter int CAW  = CADDR_W,
  parameter int BAW  = BADDR_W,
  parameter int MONN = MON_N
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobeT         stb,
  input  logic [IAW-1:0] pc,
  input  logic           engBank,
  input  logic           hostWe,
  input  logic [1:0]     hostSel,
  input  logic [BAW-1:0] hostAddr,
  input  logic [DW-1:0]  hostWdata,
  output logic [15:0]    instr,
  output logic [DW-1:0]  hostRdata
);
  localparam int IDEPTH = 2 ** IAW;
  localparam int CDEPTH = 2 ** CAW;
  localparam int BDEPTH = 2 ** BAW;
  localparam int MSW    = $clog2(MONN);
  localparam int TCW    = $clog2(TERM_MAX) + 1;
  localparam logic signed [AW-1:0] MAXV = AW'((2 ** (DW - 1)) - 1);
  localparam logic signed [AW-1:0] MINV = -MAXV - 1;

  logic [15:0]    imem [IDEPTH];
  logic [DW-1:0]  cmem [CDEPTH];
  logic [DW-1:0]  bank [2][BDEPTH];
  logic [DW-1:0]  mon  [MONN];
  logic [BAW-1:0] dataBase;

  logic signed [AW-1:0]   acc;
  logic [TCW-1:0]         termCnt;
  logic [BAW-1:0]         dataAddr;
  logic                   dlyOk;
  logic signed [DW-1:0]   xVal, cVal;
  logic signed [2*DW-1:0] prod;
  logic signed [AW-1:0]   prodExt, rndAdd, shifted;
  logic [4:0]             shAmt;
  logic [DW-1:0]          storeVal;

  assign instr    = imem[pc];
  assign dataAddr = dataBase + BAW'(stb.dataOfs);
  assign dlyOk    = stb.dlyEn && (stb.dataOfs[4:0] != 5'd31);
  assign xVal     = bank[engBank][dataAddr];
  assign cVal     = cmem[stb.coefAddr[CAW-1:0]];
  assign prod     = cVal * xVal;
  assign prodExt  = AW'(prod);

  // output scaling with optional rounding and saturation
  always_comb begin
    shAmt   = 5'(Q_BASE) + {3'b000, stb.qSel};
    rndAdd  = stb.rnd ? (AW'(1) <<< (shAmt - 5'd1)) : '0;
    shifted = (acc + rndAdd) >>> shAmt;
    if (stb.sat && shifted > MAXV)      storeVal = MAXV[DW-1:0];
    else if (stb.sat && shifted < MINV) storeVal = MINV[DW-1:0];
    else                                storeVal = shifted[DW-1:0];
  end

  // memories: host side and engine side
  always_ff @(posedge clk) begin
    if (hostWe) begin
      case (hostSel)
        2'd0: imem[hostAddr[IAW-1:0]] <= hostWdata[15:0];
        2'd1: cmem[hostAddr[CAW-1:0]] <= hostWdata;
        2'd2: bank[~engBank][hostAddr] <= hostWdata;
        default: ;
      endcase
    end
    if (dlyOk) bank[engBank][dataAddr + 1'b1] <= xVal;
    if (stb.strEn) bank[engBank][dataAddr] <= storeVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataBase <= '0;
      acc      <= '0;
      termCnt  <= '0;
      for (int i = 0; i < MONN; i++) mon[i] <= '0;
    end else begin
      if (hostWe && hostSel == 2'd3) dataBase <= hostAddr;
      if (stb.macEn) begin
        if (stb.clrAcc) begin
          acc     <= prodExt;
          termCnt <= TCW'(1);
        end else if (termCnt < TCW'(TERM_MAX)) begin
          acc     <= acc + prodExt;
          termCnt <= termCnt + 1'b1;
        end
      end
      if (stb.strEn) mon[stb.monSlot[MSW-1:0]] <= storeVal;
    end
  end

  always_comb begin
    case (hostSel)
      2'd0:    hostRdata = DW'(imem[hostAddr[IAW-1:0]]);
      2'd1:    hostRdata = cmem[hostAddr[CAW-1:0]];
      2'd2:    hostRdata = bank[~engBank][hostAddr];
      default: hostRdata = mon[hostAddr[MSW-1:0]];
    endcase
  end

  p_clr_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.macEn && stb.clrAcc) |=> acc == $past(prodExt));

  p_term_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.macEn && !stb.clrAcc && termCnt >= TCW'(TERM_MAX)) |=> acc == $past(acc));
endmodule

// File: rtl/macEngine.sv
module macEngine (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  progSel,
  input  logic        swapReq,
  output logic        busy,
  output logic        engBank,
  input  logic        hostWe,
  input  logic [1:0]  hostSel,
  input  logic [9:0]  hostAddr,
  input  logic [15:0] hostWdata,
  output logic [15:0] hostRdata
);
  import macPkg::*;

  strobeT             stb;
  logic [15:0]        instr;
  logic [IADDR_W-1:0] pc;

  macCtrl #(.IAW(IADDR_W), .PSW(SEL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .progSel(progSel),
    .swapReq(swapReq), .instr(instr), .pc(pc), .busy(busy),
    .engBank(engBank), .stb(stb)
  );

  macDatapath #(.DW(DATA_W), .AW(ACC_W), .IAW(IADDR_W), .CAW(CADDR_W),
                .BAW(BADDR_W), .MONN(MON_N)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pc(pc), .engBank(engBank),
    .hostWe(hostWe), .hostSel(hostSel), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .instr(instr), .hostRdata(hostRdata)
  );
endmodule

// File: tb/test_macEngine.sv
module test_macEngine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  progSel = '0;
  logic        swapReq = 1'b0;
  logic        busy, engBank;
  logic        hostWe = 1'b0;
  logic [1:0]  hostSel = '0;
  logic [9:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  macEngine i_macEngine (
    .clk(clk), .rstN(rstN), .start(start), .progSel(progSel),
    .swapReq(swapReq), .busy(busy), .engBank(engBank), .hostWe(hostWe),
    .hostSel(hostSel), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata)
  );

  function automatic logic [15:0] mac(bit clr, bit dly, int coef, int ofs);
    return {2'b00, clr, dly, coef[5:0], ofs[5:0]};
  endfunction
  function automatic logic [15:0] str(bit rnd, bit sat, int q, int slot, int ofs);
    return {2'b01, rnd, sat, q[1:0], slot[1:0], 2'b00, ofs[5:0]};
  endfunction
  function automatic logic [15:0] jmp(bit stop, int tgt);
    return {2'b10, stop, 5'b0, tgt[7:0]};
  endfunction

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(int sel, int addr, int data);
    @(negedge clk);
    hostWe = 1'b1; hostSel = sel[1:0]; hostAddr = addr[9:0]; hostWdata = data[15:0];
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic hostRead(int sel, int addr, output int val);
    @(negedge clk);
    hostSel = sel[1:0]; hostAddr = addr[9:0];
    #1 val = int'(hostRdata);
  endtask

  task automatic runProg(int sel, output int cyc);
    @(negedge clk);
    start = 1'b1; progSel = sel[2:0];
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic doSwap(int expBank, string tag);
    @(negedge clk); swapReq = 1'b1;
    @(negedge clk); swapReq = 1'b0;
    check(tag, int'(engBank), expBank);
  endtask

  task automatic testReset();
    int v;
    check("R1 busy after reset", int'(busy), 0);
    check("R1 engBank after reset", int'(engBank), 0);
    for (int i = 0; i < 4; i++) begin
      hostRead(3, i, v);
      check("R1 monitor after reset", v, 0);
    end
  endtask

  task automatic loadAll();
    int coefs[6] = '{16'h4000, 16'h4000, 16'h0100, 16'h4000, 16'h7FFF, 16'h0001};
    for (int i = 0; i < 6; i++) hostWrite(1, i, coefs[i]);
    hostWrite(2, 0, 16'h4000); hostWrite(2, 1, 16'h2000);
    hostWrite(2, 2, 16'h0003); hostWrite(2, 3, 16'hC000);
    hostWrite(2, 20, 16'h1111); hostWrite(2, 21, 16'h2222);
    hostWrite(2, 31, 16'h7777); hostWrite(2, 32, 16'h5A5A);
    // program 0: two-term sum
    hostWrite(0, 0, mac(1, 0, 0, 0)); hostWrite(0, 1, mac(0, 0, 1, 1));
    hostWrite(0, 2, str(0, 0, 3, 0, 60)); hostWrite(0, 3, jmp(1, 0));
    // program 1: Q selection
    hostWrite(0, 32, mac(1, 0, 2, 0)); hostWrite(0, 33, str(0, 0, 0, 1, 58));
    hostWrite(0, 34, str(0, 0, 2, 2, 59)); hostWrite(0, 35, jmp(1, 0));
    // program 2: rounding
    hostWrite(0, 64, mac(1, 0, 3, 2)); hostWrite(0, 65, str(0, 0, 3, 0, 56));
    hostWrite(0, 66, str(1, 0, 3, 1, 57)); hostWrite(0, 67, jmp(1, 0));
    // program 3: saturation
    hostWrite(0, 96, mac(1, 0, 4, 0)); hostWrite(0, 97, mac(0, 0, 4, 0));
    hostWrite(0, 98, mac(0, 0, 4, 0)); hostWrite(0, 99, str(0, 1, 0, 0, 53));
    hostWrite(0, 100, str(0, 0, 0, 1, 54)); hostWrite(0, 101, mac(1, 0, 4, 3));
    hostWrite(0, 102, mac(0, 0, 4, 3)); hostWrite(0, 103, mac(0, 0, 4, 3));
    hostWrite(0, 104, str(0, 1, 0, 2, 55)); hostWrite(0, 105, jmp(1, 0));
    // program 4: 40 terms split by a jump
    hostWrite(0, 128, mac(1, 0, 5, 1)); hostWrite(0, 129, str(0, 0, 0, 2, 50));
    for (int a = 130; a <= 158; a++) hostWrite(0, a, mac(0, 0, 5, 1));
    hostWrite(0, 159, jmp(0, 170));
    for (int a = 170; a <= 179; a++) hostWrite(0, a, mac(0, 0, 5, 1));
    hostWrite(0, 180, str(0, 0, 0, 0, 51)); hostWrite(0, 181, jmp(1, 0));
    // program 5: jump skip
    hostWrite(0, 160, mac(1, 0, 0, 0)); hostWrite(0, 161, jmp(0, 165));
    hostWrite(0, 162, str(0, 0, 3, 3, 52)); hostWrite(0, 165, mac(0, 0, 0, 0));
    hostWrite(0, 166, str(0, 0, 3, 3, 52)); hostWrite(0, 167, jmp(1, 0));
    // program 7: delay line
    hostWrite(0, 224, mac(1, 1, 0, 20)); hostWrite(0, 225, mac(0, 1, 0, 31));
    hostWrite(0, 226, jmp(1, 0));
  endtask

  task automatic testSum();
    int cyc, v;
    runProg(0, cyc);
    check("R12 busy cycles program 0", cyc, 4);
    hostRead(3, 0, v);
    check("R2 two-term sum Q15", v, 16'h3000);
  endtask

  task automatic testQSel();
    int cyc, v;
    runProg(1, cyc);
    hostRead(3, 1, v);
    check("R3 Q12 scaling", v, 16'h0400);
    hostRead(3, 2, v);
    check("R7 R3 Q14 scaling via entry 1", v, 16'h0100);
  endtask

  task automatic testRound();
    int cyc, v;
    runProg(2, cyc);
    hostRead(3, 0, v);
    check("R4 truncation", v, 1);
    hostRead(3, 1, v);
    check("R4 rounding", v, 2);
  endtask

  task automatic testSat();
    int cyc, v;
    runProg(3, cyc);
    hostRead(3, 0, v);
    check("R5 positive clamp", v, 16'h7FFF);
    hostRead(3, 1, v);
    check("R5 wrap without saturation", v, 16'hFFF4);
    hostRead(3, 2, v);
    check("R5 negative clamp", v, 16'h8000);
  endtask

  task automatic testJump();
    int cyc, v;
    runProg(5, cyc);
    check("R8 R12 busy cycles with jump", cyc, 5);
    hostRead(3, 3, v);
    check("R8 jump skips store", v, 16'h4000);
  endtask

  task automatic testCapAndSwap();
    int cyc, v, bankHeld;
    bankHeld = 1;
    @(negedge clk);
    start = 1'b1; progSel = 3'd4;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 1000) begin
      cyc++;
      if (cyc == 5) begin
        hostSel = 2'd3; hostAddr = 10'd2;
        #1 check("R11 monitor read during run", int'(hostRdata), 2);
      end
      if (cyc == 10) swapReq = 1'b1;
      if (cyc == 11) swapReq = 1'b0;
      if (engBank !== 1'b1) bankHeld = 0;
      @(negedge clk);
    end
    check("R10 bank held during run", bankHeld, 1);
    check("R12 busy cycles program 4", cyc, 44);
    check("R10 no swap at stop edge", int'(engBank), 1);
    @(negedge clk);
    check("R10 deferred swap after run", int'(engBank), 0);
    hostRead(3, 0, v);
    check("R6 32-term cap", v, 16'h0040);
  endtask

  task automatic testDelay();
    int cyc, v;
    doSwap(1, "R10 idle swap back");
    runProg(7, cyc);
    doSwap(0, "R10 idle swap after delay run");
    hostRead(2, 21, v);
    check("R9 delay move to next word", v, 16'h1111);
    hostRead(2, 20, v);
    check("R9 source word kept", v, 16'h1111);
    hostRead(2, 32, v);
    check("R9 no move past window edge", v, 16'h5A5A);
    hostRead(2, 31, v);
    check("R9 window edge word kept", v, 16'h7777);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    loadAll();
    doSwap(1, "R10 idle swap to loaded bank");
    testSum();
    testQSel();
    testRound();
    testSat();
    testJump();
    testCapAndSwap();
    testDelay();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule